// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous on-chip logic read and write an external asynchronous static RAM. The memory has 20 address bits and a 16-bit data bus split into two byte lanes. A requester hands over one access at a time: an address, write data, a read/write flag and a two-bit lane mask. The controller then runs a fixed sequence of clock cycles on the memory pins and returns a one-clock response pulse, which carries the read data for reads. Every phase length is a cycle count. Each count is derived at elaboration from the clock period parameter and the memory's minimum times in nanoseconds, rounded up, with a floor of one cycle.

The request side uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so back-pressure lasts from acceptance until the response pulse has passed. The requester must hold its request fields stable while `req_valid` is high and `req_ready` is low. The response side has no back-pressure: `rsp_valid` is high for exactly one clock per accepted request, and the requester must take the response in that clock.

On the memory side the controller drives a dual-polarity chip select, write enable, output enable and the two lane strobes, all active low except `mem_ce`. The data bus is split into an output word, a per-lane output enable for the pad driver, and an input word. Output enable is never low while the controller drives data. The controller starts driving only one clock after write enable falls, so the memory's output drivers have released the bus by then.

Top module: `sram_port_ctrl`

## Requirements
- R1: Whenever `req_ready` is high (idle, including after reset): `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lb_n`=1, `mem_ub_n`=1 and `mem_dq_oe`=0.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` high. After acceptance `req_ready` stays low until the access ends. `rsp_valid` pulses high for exactly one clock per accepted request, and responses come back in request order.
- R3: A read asserts the chip select (`mem_ce_n`=0, `mem_ce`=1), holds `mem_we_n`=1 and `mem_oe_n`=0, and keeps this for max(ceil(55/P), ceil(30/P)) clocks, where P is the clock period in ns (6 clocks at 10 ns). The data bus is sampled at the end of the last of these clocks.
- R4: Mask bit 0 selects the lower lane (`mem_dq` bits 7:0, strobe `mem_lb_n`) and bit 1 selects the upper lane (bits 15:8, `mem_ub_n`). Each strobe is low during an access only if its mask bit is set. In `rsp_rdata`, a lane that is not selected reads as zero.
- R5: Before write enable falls, the write has the chip selected and the strobes set with `mem_we_n`=1 for ceil(0/P), minimum 1, clocks. `mem_oe_n` stays high throughout a write.
- R6: Write enable is low for max(ceil(45/P), ceil(50/P)-1, ceil(25/P)+1, ceil(55/P)-2) clocks (5 clocks at 10 ns).
- R7: `mem_dq_oe[i]` rises only after `mem_we_n` has been low for one clock. It stays high through the clock after `mem_we_n` rises, only for selected lanes. It is never high while `mem_oe_n` is low. The written value is `req_wdata`.
- R8: While the chip stays selected, the address and both strobes do not change.
- R9: A write with mask 00 drives no strobe low and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 2 | Per-lane pad driver enable |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
A sequencer stuck in the wrong state would show within one clock as a select, strobe or enable pin out of place. For example, write enable might fall while output enable is low, or the chip might remain selected while `req_ready` is high. A phase counter loaded with the wrong value shows at the end of that access. Write enable stays low for the wrong number of clocks, or read data is sampled before the memory model presents it and returns junk. Wrong lane state shows at the next read-back of that address, because a stray strobe or driver enable corrupts the lane that should have kept its old byte.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WS,
    ST_WP1,
    ST_WP2,
    ST_WH,
    ST_DONE
  } st_e;

  // memory minimum times in ns for the 55 ns speed grade
  localparam int T_ACC_CYCLE  = 55;
  localparam int T_ADDR_ACC   = 55;
  localparam int T_OE_ACC     = 30;
  localparam int T_WE_PULSE   = 45;
  localparam int T_ADDR_END   = 50;
  localparam int T_LANE_END   = 45;
  localparam int T_DATA_SETUP = 25;
  localparam int T_ADDR_SETUP = 0;

  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rd_cycles(input int per);
    return imax(imax(ns2cyc(T_ACC_CYCLE, per), ns2cyc(T_ADDR_ACC, per)),
                ns2cyc(T_OE_ACC, per));
  endfunction

  function automatic int setup_cycles(input int per);
    return ns2cyc(T_ADDR_SETUP, per);
  endfunction

  // write enable low time; one setup clock before it and one hold clock after
  function automatic int pulse_cycles(input int per);
    int p;
    p = imax(ns2cyc(T_WE_PULSE, per), ns2cyc(T_LANE_END, per));
    p = imax(p, ns2cyc(T_ADDR_END, per) - setup_cycles(per));
    p = imax(p, ns2cyc(T_DATA_SETUP, per) + 1);
    p = imax(p, ns2cyc(T_ACC_CYCLE, per) - setup_cycles(per) - 1);
    return imax(p, 2);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 4,
  parameter int RD_C   = 6,
  parameter int SU_C   = 1,
  parameter int WP_C   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [1:0]        lane_n,
  output logic              drive_en,
  output logic              cap_en,
  output logic              accept,
  output logic              rsp_valid
);
  st_e        st_q, st_d;
  logic [1:0] be_q, be_d;
  logic       sel_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cap_en    = (st_q == ST_RD) && tmr_done;
  assign be_d      = accept ? req_be : be_q;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          st_d    = ST_WS;
          tmr_val = CNT_W'(SU_C - 1);
        end else begin
          st_d    = ST_RD;
          tmr_val = CNT_W'(RD_C - 1);
        end
      end
      ST_RD:  if (tmr_done) st_d = ST_DONE;
      ST_WS:  if (tmr_done) st_d = ST_WP1;
      ST_WP1: begin
        st_d     = ST_WP2;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_C - 2);
      end
      ST_WP2: if (tmr_done) st_d = ST_WH;
      ST_WH:  st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign sel_d = (st_d == ST_RD) || (st_d == ST_WS) || (st_d == ST_WP1) ||
                 (st_d == ST_WP2) || (st_d == ST_WH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      be_q      <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      lane_n    <= 2'b11;
      drive_en  <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        be_q     <= req_be;
        mem_addr <= req_addr;
      end
      mem_ce_n  <= !sel_d;
      mem_ce    <= sel_d;
      mem_oe_n  <= (st_d != ST_RD);
      mem_we_n  <= !((st_d == ST_WP1) || (st_d == ST_WP2));
      lane_n    <= sel_d ? ~be_d : 2'b11;
      drive_en  <= (st_d == ST_WP2) || (st_d == ST_WH);
      rsp_valid <= (st_d == ST_DONE);
    end
  end
endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [LANE_W-1:0] wdata,
  input  logic              lane_n,
  input  logic              drive_en,
  input  logic              cap_en,
  input  logic [LANE_W-1:0] dq_i,
  output logic [LANE_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [LANE_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o  <= '0;
      rdata <= '0;
    end else begin
      if (accept) dq_o  <= wdata;
      if (cap_en) rdata <= lane_n ? '0 : dq_i;
    end
  end

  assign dq_oe = drive_en && !lane_n;
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int LANE_W        = 8,
  parameter int CLK_PERIOD_NS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_be,
  output logic                  rsp_valid,
  output logic [2*LANE_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_ce,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic                  mem_lb_n,
  output logic                  mem_ub_n,
  output logic [2*LANE_W-1:0]   mem_dq_o,
  output logic [1:0]            mem_dq_oe,
  input  logic [2*LANE_W-1:0]   mem_dq_i
);
  localparam int LANES = 2;
  localparam int RD_C  = rd_cycles(CLK_PERIOD_NS);
  localparam int SU_C  = setup_cycles(CLK_PERIOD_NS);
  localparam int WP_C  = pulse_cycles(CLK_PERIOD_NS);
  localparam int MAX_C = imax(imax(RD_C, SU_C), WP_C);
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             tmr_load, tmr_done, drive_en, cap_en, accept;
  logic [CNT_W-1:0] tmr_val;
  logic [1:0]       lane_n;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_access_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_C(RD_C), .SU_C(SU_C), .WP_C(WP_C)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_ready(req_ready),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .lane_n(lane_n),
    .drive_en(drive_en), .cap_en(cap_en), .accept(accept), .rsp_valid(rsp_valid)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_lane_path #(.LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .wdata(req_wdata[i*LANE_W +: LANE_W]), .lane_n(lane_n[i]),
      .drive_en(drive_en), .cap_en(cap_en),
      .dq_i(mem_dq_i[i*LANE_W +: LANE_W]),
      .dq_o(mem_dq_o[i*LANE_W +: LANE_W]), .dq_oe(mem_dq_oe[i]),
      .rdata(rsp_rdata[i*LANE_W +: LANE_W])
    );
  end

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk
  import sram_port_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int CLK_PERIOD_NS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [1:0]        mem_dq_oe
);
  localparam int RD_EXP = rd_cycles(CLK_PERIOD_NS);
  localparam int WP_EXP = pulse_cycles(CLK_PERIOD_NS);

  logic [15:0] we_low_cnt, oe_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_low_cnt <= '0;
    end else begin
      we_low_cnt <= mem_we_n ? '0 : we_low_cnt + 1'b1;
      oe_low_cnt <= mem_oe_n ? '0 : oe_low_cnt + 1'b1;
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && mem_dq_oe == 2'b00)); // R1
  AST_RSP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_READ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n && oe_low_cnt != 0) |-> (oe_low_cnt == 16'(RD_EXP))); // R3
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n && mem_ce)); // R5
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R5
  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && we_low_cnt != 0) |-> (we_low_cnt == 16'(WP_EXP))); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != 2'b00) |-> mem_oe_n); // R7
  AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_dq_oe != 2'b00) && ($past(mem_dq_oe) == 2'b00)) |-> !$past(mem_we_n)); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n))); // R8
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
  .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS)
) u_chk (.*);

// File: tb/test_sram_port_ctrl.sv
module test_sram_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic [1:0]  mem_dq_oe;

  int checks = 0, errors = 0;
  logic [15:0] model_mem [int];
  logic [15:0] shadow [int];
  typedef struct { bit wr; logic [15:0] data; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  sram_port_ctrl i_sram_port_ctrl (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] peek(input logic [15:0] arr [int], input int a);
    return arr.exists(a) ? arr[a] : 16'h0000;
  endfunction

  // memory model: data appears 5 edges after a read becomes active
  wire sel = !mem_ce_n && mem_ce;
  int  rd_age = 0;
  always @(posedge clk) rd_age <= (sel && !mem_oe_n && mem_we_n) ? rd_age + 1 : 0;
  always_comb begin
    logic [15:0] w;
    w = peek(model_mem, int'(mem_addr));
    mem_dq_i = 16'hEEEE;
    if (sel && mem_we_n && !mem_oe_n && rd_age >= 5) begin
      if (!mem_lb_n) mem_dq_i[7:0]  = w[7:0];
      if (!mem_ub_n) mem_dq_i[15:8] = w[15:8];
    end
  end

  // monitor
  logic        p_we = 1'b1, p_oe = 1'b1, p_sel = 1'b0, p_rsp = 1'b0;
  logic [19:0] p_addr = '0;
  logic [1:0]  p_ln = 2'b11;
  int          we_cnt = 0, oe_cnt = 0;
  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n) we_cnt++;
    if (!mem_oe_n) oe_cnt++;
    if (p_we && !mem_we_n) check(p_sel && sel, "R5 select before WE fall", {31'b0, p_sel}, 32'd1);
    if (!mem_we_n) check(mem_oe_n, "R5 OE high during write", {31'b0, mem_oe_n}, 32'd1);
    if (!p_we && mem_we_n) begin
      check(we_cnt == 5, "R6 WE low clocks", we_cnt, 5);
      we_cnt = 0;
      if (sel) begin
        logic [15:0] w;
        w = peek(model_mem, int'(mem_addr));
        if (!mem_lb_n) begin
          check(mem_dq_oe[0], "R7 lower driven at WE rise", {30'b0, mem_dq_oe}, {30'b0, ~mem_ub_n, 1'b1});
          w[7:0] = mem_dq_o[7:0];
        end
        if (!mem_ub_n) begin
          check(mem_dq_oe[1], "R7 upper driven at WE rise", {30'b0, mem_dq_oe}, {30'b0, 1'b1, ~mem_lb_n});
          w[15:8] = mem_dq_o[15:8];
        end
        model_mem[int'(mem_addr)] = w;
      end
    end
    if (!p_oe && mem_oe_n) begin
      check(oe_cnt == 6, "R3 read clocks", oe_cnt, 6);
      oe_cnt = 0;
    end
    if (mem_dq_oe != 2'b00) begin
      check(mem_oe_n && !p_we, "R7 drive timing", {30'b0, mem_oe_n, p_we}, 32'd2);
      check((mem_dq_oe & {mem_ub_n, mem_lb_n}) == 2'b00, "R7 lane drive", {30'b0, mem_dq_oe}, {30'b0, ~mem_ub_n, ~mem_lb_n});
    end
    if (sel && p_sel)
      check(mem_addr == p_addr && {mem_ub_n, mem_lb_n} == p_ln, "R8 stable while selected",
            {10'b0, mem_addr, mem_ub_n, mem_lb_n}, {10'b0, p_addr, p_ln});
    if (rsp_valid) begin
      check(!p_rsp, "R2 single-clock response", 32'd1, 32'd0);
      if (sb_q.size() == 0) check(1'b0, "R2 unexpected response", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        if (!it.wr) check(rsp_rdata == it.data, "R4 read data", {16'b0, rsp_rdata}, {16'b0, it.data});
      end
    end
    p_we = mem_we_n; p_oe = mem_oe_n; p_sel = sel; p_rsp = rsp_valid;
    p_addr = mem_addr; p_ln = {mem_ub_n, mem_lb_n};
  end

  // driver
  task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    it.wr = wr;
    if (wr) begin
      logic [15:0] s;
      s = peek(shadow, int'(a));
      if (be[0]) s[7:0]  = d[7:0];
      if (be[1]) s[15:8] = d[15:8];
      shadow[int'(a)] = s;
      it.data = '0;
    end else begin
      logic [15:0] s;
      s = peek(shadow, int'(a));
      it.data = {be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00};
    end
    sb_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2 busy after accept", {31'b0, req_ready}, 32'd0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && mem_dq_oe == 2'b00,
          "R1 idle after reset", {24'b0, req_ready, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, |mem_dq_oe},
          32'b1101_1110);
    access(1, 20'h00000, 16'hA5C3, 2'b11);
    access(0, 20'h00000, 16'h0000, 2'b11);
    access(1, 20'hFFFFF, 16'h1234, 2'b11);
    access(1, 20'hFFFFF, 16'hFFEE, 2'b01);  // R4 lower lane only
    access(0, 20'hFFFFF, 16'h0000, 2'b11);
    access(1, 20'hFFFFF, 16'h99AA, 2'b10);  // R4 upper lane only
    access(1, 20'hFFFFF, 16'h0000, 2'b00);  // R9 empty mask
    access(0, 20'hFFFFF, 16'h0000, 2'b11);  // R9 unchanged
    access(0, 20'hFFFFF, 16'h0000, 2'b01);
    access(0, 20'hFFFFF, 16'h0000, 2'b10);
    access(0, 20'hFFFFF, 16'h0000, 2'b00);
    begin
      logic [31:0] lcg;
      lcg = 32'h1357_9BDF;
      for (int k = 0; k < 24; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        access(lcg[31], {16'h0, lcg[3:0]}, lcg[27:12], lcg[9:8]);
      end
      for (int k = 0; k < 16; k++) access(0, 20'(k), 16'h0, 2'b11);
    end
    repeat (12) @(negedge clk);
    check(sb_q.size() == 0, "R2 all responses returned", sb_q.size(), 0);
    check(req_ready && mem_ce_n && mem_oe_n && mem_we_n, "R1 idle at end",
          {28'b0, req_ready, mem_ce_n, mem_oe_n, mem_we_n}, 32'hF);
    finish_run();
  end
endmodule